// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block gathers interrupt requests from twelve fixed sources and presents one 3-bit request level to a processor. Each source has a byte-wide control register. The register holds an enable bit, a 3-bit level and a pending flag that reads back on bit 7. The block compares the enabled pending sources and drives the highest level. Two sources at the same level are resolved in favour of the lower source number. A global enable gates every source at once.

When the processor runs an interrupt-acknowledge cycle, it quotes the level it is servicing. If that level equals the level on `irq_lvl`, the block answers with an 8-bit vector. The vector is a programmable base plus the number of the winning source. If the levels differ, the block answers with a spurious response. The source numbers are: 0 power fail, 1 bus error, 2 abort switch, 3 serial, 4 ethernet, 5 SCSI, 6 DMA, 7 printer, 8 timer 1, 9 timer 2, 10 soft request 1 and 11 soft request 2.

There are three kinds of source. Edge sources latch a rising input and hold it until software clears it. Level sources follow their input. Soft sources are raised and cleared by register writes only. The serial source can either take its vector from this block or leave the vector to its own device.

The acknowledge handshake is a four-state machine:
- `ST_IDLE` waits for `iack_req`. It moves to `ST_GRANT` when the quoted level matches a non-zero `irq_lvl`, and to `ST_REJECT` otherwise.
- `ST_GRANT` presents `ack_valid` for one cycle, then moves to `ST_RELEASE`.
- `ST_REJECT` presents `ack_spur` for one cycle, then moves to `ST_RELEASE`.
- `ST_RELEASE` stays put while `iack_req` is high and returns to `ST_IDLE` once it drops.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, every control register reads 0x00 and the general control register reads 0x00. The vector base reads 0x40, and `irq_lvl` is 0.
- R2: Edge sources 0, 1, 2, 8 and 9 set pending one clock after a rising input. Pending then stays set after the input falls, and after writes with bit 7 = 0. Only a write with bit 7 = 1 clears it; a rising edge in that same cycle wins.
- R3: For level sources 3 to 7, bit 7 reads the live input level. A write with bit 7 = 1 has no effect on it.
- R4: A write to soft source 10 or 11 with bit 7 = 0 and bit 3 = 1 makes it pending. A write with bit 7 = 1 clears it.
- R5: Register addresses 0 to 11 are the source control registers, address 12 is general control and address 13 is the vector base. In a control register, bit 3 is enable and bits 2:0 are level, and both read back as written.
- R6: Bit 4 of general control is a global enable. While it is 0, `irq_lvl` is 0 whatever is pending.
- R7: `irq_lvl` is the largest level among sources that are pending and enabled. A level of 0 never qualifies, and `irq_lvl` is 0 when no source qualifies.
- R8: An acknowledge whose `iack_lvl` equals a non-zero `irq_lvl` gives `ack_valid` for exactly one cycle, one clock after `iack_req` is sampled. `ack_vector` then equals the base plus the winner's number, modulo 256. At equal levels the lower source number wins.
- R9: An acknowledge whose level differs from `irq_lvl`, or arrives while `irq_lvl` is 0, gives `ack_spur` for one cycle and no `ack_valid`.
- R10: After a response, no further response is given until `iack_req` has been seen low.
- R11: Bit 6 of the abort control register (source 2) reads the live, unlatched abort input.
- R12: Bit 4 of the serial control register (source 3) is stored. When it is 1, the block supplies the vector (`ack_devvec` = 0). When it is 0, `ack_devvec` = 1 and `ack_vector` = 0. Bit 4 of every other source reads 0.
- R13: An acknowledge never clears a pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_in | input | 12 | Request inputs, bit i is source i (bits 10 and 11 unused) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| irq_lvl | output | 3 | Requested level toward the processor |
| iack_req | input | 1 | Acknowledge cycle request |
| iack_lvl | input | 3 | Level being acknowledged |
| ack_valid | output | 1 | Vector response, one cycle |
| ack_spur | output | 1 | Spurious response, one cycle |
| ack_devvec | output | 1 | With `ack_valid`: the device supplies the vector |
| ack_vector | output | 8 | Vector returned with `ack_valid` |

## Verification
Priority selection is driven from a table of level-source patterns. The table covers:
- distinct levels, which shows that the maximum is taken;
- all-equal levels with different active subsets, which shows the lower-index tie rule;
- sources set to level 0 while their inputs are asserted, which shows that level 0 is excluded;
- an all-idle case, which must produce a spurious acknowledge.

Every table entry is also acknowledged, so each winner's vector is checked as well as its level. Directed tests then cover:
- the edge, level and soft pending disciplines, tested against each other with write-1-clear;
- global gating;
- the live abort bit;
- the serial vector bypass;
- base wrap-around;
- a held acknowledge request.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

    typedef enum logic [1:0] {
        SRC_EDGE  = 2'd0,
        SRC_LEVEL = 2'd1,
        SRC_SOFT  = 2'd2
    } src_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_GRANT   = 2'd1,
        ST_REJECT  = 2'd2,
        ST_RELEASE = 2'd3
    } ack_state_e;

    localparam int CTL_PEND_BIT = 7;
    localparam int CTL_LIVE_BIT = 6;
    localparam int CTL_VSEL_BIT = 4;
    localparam int CTL_EN_BIT   = 3;
    localparam int GCTL_GIE_BIT = 4;

endpackage

// File: rtl/irq_src_slot.sv
module irq_src_slot
    import irq_vec_pkg::*;
#(
    parameter src_kind_e KIND     = SRC_LEVEL,
    parameter bit        HAS_VSEL = 1'b0,
    parameter bit        HAS_LIVE = 1'b0,
    parameter int        LVL_W    = 3,
    parameter int        DATA_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wr_data,
    output logic              pend,
    output logic              en,
    output logic [LVL_W-1:0]  lvl,
    output logic              vsel,
    output logic [DATA_W-1:0] rd_byte
);

    logic             en_q;
    logic [LVL_W-1:0] lvl_q;
    logic             vsel_q;
    logic             clr_req;

    assign clr_req = wr_hit && wr_data[CTL_PEND_BIT];

    // Configuration fields: enable, level, optional vector select.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            lvl_q  <= '0;
            vsel_q <= 1'b0;
        end else if (wr_hit) begin
            en_q   <= wr_data[CTL_EN_BIT];
            lvl_q  <= wr_data[LVL_W-1:0];
            vsel_q <= HAS_VSEL ? wr_data[CTL_VSEL_BIT] : 1'b0;
        end
    end

    generate
        if (KIND == SRC_EDGE) begin : g_edge
            logic prev_q;
            logic pend_q;
            logic rise;

            assign rise = src && !prev_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    prev_q <= 1'b0;
                    pend_q <= 1'b0;
                end else begin
                    prev_q <= src;
                    if (rise)
                        pend_q <= 1'b1;
                    else if (clr_req)
                        pend_q <= 1'b0;
                end
            end
            assign pend = pend_q;

            AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
                (src && !prev_q) |=> pend); // R2
            AST_EDGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
                (pend && !clr_req) |=> pend); // R2
        end else if (KIND == SRC_SOFT) begin : g_soft
            logic pend_q;
            logic unused_src;

            assign unused_src = src;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    pend_q <= 1'b0;
                else if (clr_req)
                    pend_q <= 1'b0;
                else if (wr_hit && wr_data[CTL_EN_BIT])
                    pend_q <= 1'b1;
            end
            assign pend = pend_q;

            AST_SOFT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
                clr_req |=> !pend); // R4
        end else begin : g_level
            assign pend = src;
        end
    endgenerate

    logic [1:0] unused_wr;
    assign unused_wr = wr_data[CTL_LIVE_BIT:CTL_VSEL_BIT+1];

    assign en   = en_q;
    assign lvl  = lvl_q;
    assign vsel = vsel_q;

    always_comb begin
        rd_byte                = '0;
        rd_byte[CTL_PEND_BIT]  = pend;
        rd_byte[CTL_LIVE_BIT]  = HAS_LIVE ? src : 1'b0;
        rd_byte[CTL_VSEL_BIT]  = vsel_q;
        rd_byte[CTL_EN_BIT]    = en_q;
        rd_byte[LVL_W-1:0]     = lvl_q;
    end

endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
    parameter int NSRC  = 12,
    parameter int LVL_W = 3,
    parameter int IDX_W = $clog2(NSRC)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NSRC-1:0]            qual,
    input  logic [NSRC-1:0][LVL_W-1:0] lvl,
    output logic [LVL_W-1:0]           out_lvl,
    output logic [IDX_W-1:0]           win_idx
);

    // Scan from the top index down; ">=" lets a lower index take a tie.
    always_comb begin
        out_lvl = '0;
        win_idx = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (qual[i] && (lvl[i] != '0) && (lvl[i] >= out_lvl)) begin
                out_lvl = lvl[i];
                win_idx = IDX_W'(i);
            end
        end
    end

    generate
        for (genvar g = 0; g < NSRC; g++) begin : g_chk
            AST_PRIO_MAX: assert property (@(posedge clk) disable iff (!rst_n)
                qual[g] |-> (lvl[g] <= out_lvl)); // R7
        end
    endgenerate

endmodule

// File: rtl/irq_ack_fsm.sv
module irq_ack_fsm
    import irq_vec_pkg::*;
#(
    parameter int LVL_W  = 3,
    parameter int DATA_W = 8,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iack_req,
    input  logic [LVL_W-1:0]  iack_lvl,
    input  logic [LVL_W-1:0]  cur_lvl,
    input  logic [IDX_W-1:0]  win_idx,
    input  logic              win_dev,
    input  logic [DATA_W-1:0] vec_base,
    output logic              ack_valid,
    output logic              ack_spur,
    output logic              ack_devvec,
    output logic [DATA_W-1:0] ack_vector
);

    ack_state_e        state_q, state_d;
    logic              hit;
    logic [DATA_W-1:0] vec_q;
    logic              dev_q;

    assign hit = (cur_lvl != '0) && (iack_lvl == cur_lvl);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (iack_req) state_d = hit ? ST_GRANT : ST_REJECT;
            ST_GRANT:   state_d = ST_RELEASE;
            ST_REJECT:  state_d = ST_RELEASE;
            ST_RELEASE: if (!iack_req) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Winner capture on entry to ST_GRANT
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_q <= '0;
            dev_q <= 1'b0;
        end else if (state_q == ST_IDLE && iack_req && hit) begin
            vec_q <= win_dev ? '0 : (vec_base + DATA_W'(win_idx));
            dev_q <= win_dev;
        end
    end

    // Outputs
    always_comb begin
        ack_valid  = 1'b0;
        ack_spur   = 1'b0;
        ack_devvec = 1'b0;
        ack_vector = '0;
        unique case (state_q)
            ST_GRANT: begin
                ack_valid  = 1'b1;
                ack_devvec = dev_q;
                ack_vector = vec_q;
            end
            ST_REJECT:  ack_spur = 1'b1;
            default: ;
        endcase
    end

    AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ack_valid, ack_spur})); // R9
    AST_GRANT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |=> !ack_valid); // R8
    AST_HELD_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
        ((ack_valid || ack_spur) && iack_req) |=> !(ack_valid || ack_spur)); // R10

endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
    import irq_vec_pkg::*;
#(
    parameter int          NSRC      = 12,
    parameter int          LVL_W     = 3,
    parameter int          DATA_W    = 8,
    parameter int          ADDR_W    = 4,
    parameter logic [11:0] EDGE_MASK = 12'b0011_0000_0111,
    parameter logic [11:0] SOFT_MASK = 12'b1100_0000_0000,
    parameter logic [11:0] VSEL_MASK = 12'b0000_0000_1000,
    parameter logic [11:0] LIVE_MASK = 12'b0000_0000_0100,
    parameter logic [7:0]  BASE_RST  = 8'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [LVL_W-1:0]  irq_lvl,
    input  logic              iack_req,
    input  logic [LVL_W-1:0]  iack_lvl,
    output logic              ack_valid,
    output logic              ack_spur,
    output logic              ack_devvec,
    output logic [DATA_W-1:0] ack_vector
);

    localparam int IDX_W      = $clog2(NSRC);
    localparam int ADDR_GCTL  = NSRC;
    localparam int ADDR_VBASE = NSRC + 1;

    logic                        gie_q;
    logic [DATA_W-1:0]           base_q;
    logic [NSRC-1:0]             pend, en, vsel, dev_sel, qual;
    logic [NSRC-1:0][LVL_W-1:0]  lvl;
    logic [NSRC-1:0][DATA_W-1:0] rd_bytes;
    logic [IDX_W-1:0]            win_idx;

    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_src
            localparam src_kind_e K = SOFT_MASK[i] ? SRC_SOFT :
                                      (EDGE_MASK[i] ? SRC_EDGE : SRC_LEVEL);
            irq_src_slot #(
                .KIND     (K),
                .HAS_VSEL (VSEL_MASK[i]),
                .HAS_LIVE (LIVE_MASK[i]),
                .LVL_W    (LVL_W),
                .DATA_W   (DATA_W)
            ) u_slot (
                .clk     (clk),
                .rst_n   (rst_n),
                .src     (src_in[i]),
                .wr_hit  (wr_en && (wr_addr == ADDR_W'(i))),
                .wr_data (wr_data),
                .pend    (pend[i]),
                .en      (en[i]),
                .lvl     (lvl[i]),
                .vsel    (vsel[i]),
                .rd_byte (rd_bytes[i])
            );
            assign dev_sel[i] = VSEL_MASK[i] && !vsel[i];
        end
    endgenerate

    // Global control and vector base
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gie_q  <= 1'b0;
            base_q <= BASE_RST;
        end else if (wr_en) begin
            if (wr_addr == ADDR_W'(ADDR_GCTL))
                gie_q <= wr_data[GCTL_GIE_BIT];
            if (wr_addr == ADDR_W'(ADDR_VBASE))
                base_q <= wr_data;
        end
    end

    assign qual = pend & en & {NSRC{gie_q}};

    irq_prio_sel #(
        .NSRC  (NSRC),
        .LVL_W (LVL_W),
        .IDX_W (IDX_W)
    ) u_prio (
        .clk     (clk),
        .rst_n   (rst_n),
        .qual    (qual),
        .lvl     (lvl),
        .out_lvl (irq_lvl),
        .win_idx (win_idx)
    );

    irq_ack_fsm #(
        .LVL_W  (LVL_W),
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_ack (
        .clk        (clk),
        .rst_n      (rst_n),
        .iack_req   (iack_req),
        .iack_lvl   (iack_lvl),
        .cur_lvl    (irq_lvl),
        .win_idx    (win_idx),
        .win_dev    (dev_sel[win_idx]),
        .vec_base   (base_q),
        .ack_valid  (ack_valid),
        .ack_spur   (ack_spur),
        .ack_devvec (ack_devvec),
        .ack_vector (ack_vector)
    );

    // Register read mux
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NSRC; i++)
            if (rd_addr == ADDR_W'(i))
                rd_data = rd_bytes[i];
        if (rd_addr == ADDR_W'(ADDR_GCTL))
            rd_data[GCTL_GIE_BIT] = gie_q;
        if (rd_addr == ADDR_W'(ADDR_VBASE))
            rd_data = base_q;
    end

    AST_GIE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        !gie_q |-> (irq_lvl == '0)); // R6
    AST_GRANT_MATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> ($past(iack_lvl) == $past(irq_lvl) && $past(irq_lvl) != '0)); // R8

endmodule

// File: tb/tb_irq_vec_ctrl.sv
module tb_irq_vec_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] src_in = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic [2:0]  irq_lvl;
    logic        iack_req = 1'b0;
    logic [2:0]  iack_lvl = '0;
    logic        ack_valid, ack_spur, ack_devvec;
    logic [7:0]  ack_vector;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    irq_vec_ctrl dut (
        .clk(clk), .rst_n(rst_n), .src_in(src_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq_lvl(irq_lvl),
        .iack_req(iack_req), .iack_lvl(iack_lvl),
        .ack_valid(ack_valid), .ack_spur(ack_spur),
        .ack_devvec(ack_devvec), .ack_vector(ack_vector)
    );

    // Entry: {lvl src7..src3 (3b each), active mask src7..src3, expected level, expected index}
    localparam logic [26:0] PRIO_TAB [8] = '{
        {3'd5,3'd4,3'd3,3'd2,3'd1, 5'b11111, 3'd5, 4'd7},
        {3'd5,3'd4,3'd3,3'd2,3'd1, 5'b00011, 3'd2, 4'd4},
        {3'd4,3'd4,3'd4,3'd4,3'd4, 5'b11111, 3'd4, 4'd3},
        {3'd4,3'd4,3'd4,3'd4,3'd4, 5'b11100, 3'd4, 4'd5},
        {3'd0,3'd0,3'd0,3'd7,3'd0, 5'b11111, 3'd7, 4'd4},
        {3'd0,3'd0,3'd0,3'd0,3'd0, 5'b11111, 3'd0, 4'd0},
        {3'd3,3'd2,3'd6,3'd1,3'd6, 5'b11110, 3'd6, 4'd5},
        {3'd3,3'd3,3'd3,3'd7,3'd7, 5'b00001, 3'd7, 4'd3}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    // Ack cycle: returns the response seen one clock after iack_req is sampled.
    task automatic ack(input logic [2:0] l, output logic v, output logic s,
                       output logic dv, output logic [7:0] vec);
        @(negedge clk);
        iack_req = 1'b1; iack_lvl = l;
        @(negedge clk);
        v = ack_valid; s = ack_spur; dv = ack_devvec; vec = ack_vector;
        iack_req = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++; n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [7:0] r;
        logic v, s, dv;
        logic [7:0] vec;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq_lvl", 32'(irq_lvl), 0);
        rd(4'd13, r); check("R1 vector base", 32'(r), 32'h40);
        rd(4'd12, r); check("R1 general control", 32'(r), 0);
        rd(4'd8, r);  check("R1 timer1 ctrl", 32'(r), 0);

        // R5 / R12 register layout
        wr(4'd8, 8'h1D); rd(4'd8, r);
        check("R5 enable+level readback, R12 bit4 ignored", 32'(r), 32'h0D);
        wr(4'd3, 8'h1A); rd(4'd3, r);
        check("R12 serial bit4 stored", 32'(r), 32'h1A);
        wr(4'd12, 8'h10); rd(4'd12, r);
        check("R5 general control readback", 32'(r), 32'h10);

        // Priority table (R7, R8)
        for (int k = 0; k < 8; k++) begin
            logic [26:0] e;
            e = PRIO_TAB[k];
            for (int j = 0; j < 5; j++)
                wr(4'(3 + j), {4'b0001, 1'b1, e[12 + 3*j +: 3]});
            src_in[7:3] = e[11:7];
            @(negedge clk);
            check($sformatf("R7 table %0d level", k), 32'(irq_lvl), 32'(e[6:4]));
            ack(e[6:4], v, s, dv, vec);
            if (e[6:4] != 0) begin
                check($sformatf("R8 table %0d valid", k), 32'(v), 1);
                check($sformatf("R8 table %0d vector", k), 32'(vec), 32'h40 + 32'(e[3:0]));
            end else begin
                check($sformatf("R9 table %0d spurious on idle", k), {31'd0, s}, 1);
                check($sformatf("R9 table %0d no valid", k), 32'(v), 0);
            end
        end
        src_in[7:3] = '0;
        for (int j = 3; j < 8; j++) wr(4'(j), 8'h00);

        // R2 edge latching on timer 1 (level 5)
        wr(4'd8, 8'h0D);
        @(negedge clk); src_in[8] = 1'b1;
        @(negedge clk); src_in[8] = 1'b0;
        rd(4'd8, r); check("R2 edge latched", 32'(r[7]), 1);
        check("R2 irq level from timer", 32'(irq_lvl), 5);
        repeat (2) @(negedge clk);
        rd(4'd8, r); check("R2 held after input fall", 32'(r[7]), 1);
        wr(4'd8, 8'h0D); rd(4'd8, r); check("R2 write 0 keeps pending", 32'(r[7]), 1);

        // R13 ack does not clear
        ack(3'd5, v, s, dv, vec);
        check("R13 vector timer1", 32'(vec), 32'h48);
        rd(4'd8, r); check("R13 pending after ack", 32'(r[7]), 1);

        // R6 global gate
        wr(4'd12, 8'h00); check("R6 gated off", 32'(irq_lvl), 0);
        wr(4'd12, 8'h10); check("R6 gated on", 32'(irq_lvl), 5);

        // R9 level mismatch
        ack(3'd3, v, s, dv, vec);
        check("R9 mismatch spurious", {31'd0, s}, 1);
        check("R9 mismatch no valid", 32'(v), 0);

        wr(4'd8, 8'h8D); rd(4'd8, r); check("R2 write1 clears", 32'(r[7]), 0);
        check("R2 level drops after clear", 32'(irq_lvl), 0);

        // R11 live abort bit
        @(negedge clk); src_in[2] = 1'b1;
        @(negedge clk); rd(4'd2, r); check("R11 abort live high", 32'(r[6]), 1);
        src_in[2] = 1'b0; rd(4'd2, r); check("R11 abort live low", 32'(r[6]), 0);
        check("R2 abort stays latched", 32'(r[7]), 1);
        wr(4'd2, 8'h80);

        // R4 soft sources
        wr(4'd10, 8'h0B); rd(4'd10, r);
        check("R4 soft set", 32'(r[7]), 1);
        check("R4 soft level", 32'(irq_lvl), 3);
        wr(4'd10, 8'h8B); rd(4'd10, r);
        check("R4 soft clear", 32'(r[7]), 0);
        check("R4 soft level gone", 32'(irq_lvl), 0);

        // R3 level source ignores write-1
        src_in[5] = 1'b1;
        wr(4'd5, 8'h8A); rd(4'd5, r);
        check("R3 level follows input", 32'(r[7]), 1);
        check("R3 level request", 32'(irq_lvl), 2);
        src_in[5] = 1'b0; #1; rd(4'd5, r);
        check("R3 level drops with input", 32'(r[7]), 0);
        wr(4'd5, 8'h00);

        // R12 serial vector bypass
        src_in[3] = 1'b1;
        wr(4'd3, 8'h0C);
        ack(3'd4, v, s, dv, vec);
        check("R12 device vector flag", 32'(dv), 1);
        check("R12 device vector zero", 32'(vec), 0);
        wr(4'd3, 8'h1C);
        ack(3'd4, v, s, dv, vec);
        check("R12 block vector flag", 32'(dv), 0);
        check("R12 block vector", 32'(vec), 32'h43);
        src_in[3] = 1'b0; wr(4'd3, 8'h00);

        // R8 base wrap with timer 2 (index 9)
        wr(4'd13, 8'hF8);
        wr(4'd9, 8'h0E);
        @(negedge clk); src_in[9] = 1'b1;
        @(negedge clk); src_in[9] = 1'b0;
        ack(3'd6, v, s, dv, vec);
        check("R8 wrapped vector", 32'(vec), 32'h01);

        // R10 held request
        @(negedge clk); iack_req = 1'b1; iack_lvl = 3'd6;
        @(negedge clk); check("R10 first response", 32'(ack_valid), 1);
        @(negedge clk); check("R10 no repeat while held", {31'd0, ack_valid | ack_spur}, 0);
        @(negedge clk); check("R10 still none while held", {31'd0, ack_valid | ack_spur}, 0);
        iack_req = 1'b0;
        repeat (2) @(negedge clk);
        ack(3'd6, v, s, dv, vec);
        check("R10 response after release", 32'(v), 1);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule